// File: doc/BRIEF.md
# Floppy Controller Host Register File

This block holds the byte-wide registers that a host processor sees in a floppy disk controller: a command register, a status window, a track counter, a sector register and a data holding register. The host reaches them over a small parallel bus. The bus has a select, separate read and write strobes, and a 2-bit register address. Read data comes back registered, one clock after the read strobe. The status byte is produced elsewhere and only passed through. The command byte is handed to an external sequencer with a one-cycle valid pulse.

On the drive side, the track counter follows head step pulses. The track and sector values are compared against the numbers decoded from a recorded sector ID field, and each comparison gives its own match flag. The data register sits between the host and the serial path. A byte assembled from the disk can be dropped into it in parallel, and the serializer takes its contents in parallel. Both events raise a data-request flag, and a host access to the data register clears that flag.

While a command is busy, the host may not disturb the track or sector registers. It may issue only a force-interrupt command.

Top module: `fdc_host_regs`

## Requirements
- R1: After a synchronous reset, the track, sector, data and command registers are 0, `drq` is 0, `cmd_valid` is 0 and `bus_rdata` is 0.
- R2: The register address map is fixed. Address 0 reads the `status_in` port and writes the command register; a read of address 0 never returns the command. Address 1 is the track register, address 2 the sector register and address 3 the data register. Read data appears on `bus_rdata` after the clock edge that samples `bus_sel && bus_rd`, and it holds until the next read.
- R3: Each cycle with `step_in` high and `step_out` low adds one to the track register. Each cycle with `step_out` high and `step_in` low subtracts one. The count wraps modulo 256. When both are high, the track register is unchanged.
- R4: While `busy` is high, bus writes to the track and sector registers are ignored.
- R5: When `busy` is low, any write to address 0 loads `cmd_out` and pulses `cmd_valid` high for one cycle. When `busy` is high, the write is accepted only if bits [7:4] equal 4'b1101 (force interrupt). Otherwise `cmd_out` keeps its value and `cmd_valid` stays low.
- R6: `track_match` is high exactly when the track register equals `id_track`. `sector_match` is high exactly when the sector register equals `id_sector`. Both follow their inputs in the same cycle.
- R7: The data register is loaded by a bus write to address 3, whether or not `busy` is high. It is also loaded from `asm_byte` when `asm_valid` is high. If both happen in the same cycle, `asm_byte` wins. `ser_byte` always shows the data register.
- R8: `drq` is set by `asm_valid` or `ser_take` and cleared by a bus read or write of address 3. If a set and a clear fall in the same cycle, the flag ends up set.
- R9: An accepted bus write to the track register in the same cycle as a step pulse loads the written value, and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| busy | input | 1 | Command in progress |
| status_in | input | 8 | Status byte from the sequencer |
| cmd_out | output | 8 | Last accepted command |
| cmd_valid | output | 1 | One-cycle pulse on command acceptance |
| step_in | input | 1 | Head stepped toward the spindle |
| step_out | input | 1 | Head stepped toward track 0 |
| id_track | input | 8 | Track number read from an ID field |
| id_sector | input | 8 | Sector number read from an ID field |
| track_match | output | 1 | Track register equals `id_track` |
| sector_match | output | 1 | Sector register equals `id_sector` |
| asm_valid | input | 1 | Assembled disk byte is ready |
| asm_byte | input | 8 | Assembled disk byte |
| ser_take | input | 1 | Serializer takes the data register |
| ser_byte | output | 8 | Data register contents for the serializer |
| drq | output | 1 | Data request flag |

## Verification
Two pairs of functions can collide in a single clock.

The first pair is a head step and a host write to the track register. The bench raises `step_in` in the same cycle as an accepted write to address 1. It expects the written value, with no increment applied.

The second pair is a disk byte arriving in the data register and a host access to that register. The bench sets `asm_valid` together with a bus write to address 3. It then reads back the assembled byte, not the written one. It also pairs `asm_valid` with a bus read of address 3 and expects `drq` to remain high afterwards.

// File: rtl/fdc_regs_pkg.sv
package fdc_regs_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_STAT_CMD = 2'd0,
    RA_TRACK    = 2'd1,
    RA_SECTOR   = 2'd2,
    RA_DATA     = 2'd3
  } fdc_addr_e;
endpackage

// File: rtl/fdc_bus_decode.sv
module fdc_bus_decode
  import fdc_regs_pkg::*;
#(
  parameter int DW        = 8,
  parameter int NIB_W     = 4,
  parameter logic [NIB_W-1:0] FORCE_NIB = 4'hD
) (
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  input  logic                busy,
  output logic                we_track,
  output logic                we_sector,
  output logic                we_data,
  output logic                cmd_accept,
  output logic                data_touch
);
  localparam int NIB_LSB = DW - NIB_W;

  fdc_addr_e addr_e;
  logic      wr_q, rd_q, is_force;

  always_comb begin
    addr_e     = fdc_addr_e'(bus_addr);
    wr_q       = bus_sel && bus_wr;
    rd_q       = bus_sel && bus_rd;
    is_force   = (bus_wdata[DW-1:NIB_LSB] == FORCE_NIB);
    we_track   = wr_q && (addr_e == RA_TRACK)  && !busy;
    we_sector  = wr_q && (addr_e == RA_SECTOR) && !busy;
    we_data    = wr_q && (addr_e == RA_DATA);
    cmd_accept = wr_q && (addr_e == RA_STAT_CMD) && (!busy || is_force);
    data_touch = (wr_q || rd_q) && (addr_e == RA_DATA);
  end
endmodule

// File: rtl/fdc_track_ctr.sv
module fdc_track_ctr #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [DW-1:0] load_val,
  input  logic          step_in,
  input  logic          step_out,
  output logic [DW-1:0] track_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      track_q <= '0;
    end else if (load_en) begin
      track_q <= load_val;
    end else if (step_in && !step_out) begin
      track_q <= track_q + 1'b1;
    end else if (step_out && !step_in) begin
      track_q <= track_q - 1'b1;
    end
  end
endmodule

// File: rtl/fdc_data_hold.sv
module fdc_data_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_load,
  input  logic [DW-1:0] bus_val,
  input  logic          asm_valid,
  input  logic [DW-1:0] asm_byte,
  input  logic          ser_take,
  input  logic          bus_touch,
  output logic [DW-1:0] data_q,
  output logic          drq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (asm_valid) begin
      data_q <= asm_byte;
    end else if (bus_load) begin
      data_q <= bus_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drq <= 1'b0;
    end else if (asm_valid || ser_take) begin
      drq <= 1'b1;
    end else if (bus_touch) begin
      drq <= 1'b0;
    end
  end
endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
  import fdc_regs_pkg::*;
#(
  parameter int DW = REG_W,
  parameter logic [3:0] FORCE_NIB = 4'hD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              busy,
  input  logic [DW-1:0]     status_in,
  output logic [DW-1:0]     cmd_out,
  output logic              cmd_valid,
  input  logic              step_in,
  input  logic              step_out,
  input  logic [DW-1:0]     id_track,
  input  logic [DW-1:0]     id_sector,
  output logic              track_match,
  output logic              sector_match,
  input  logic              asm_valid,
  input  logic [DW-1:0]     asm_byte,
  input  logic              ser_take,
  output logic [DW-1:0]     ser_byte,
  output logic              drq
);
  logic          we_track, we_sector, we_data, cmd_accept, data_touch;
  logic [DW-1:0] track_q, sector_q, data_q, rd_mux;

  fdc_bus_decode #(.DW(DW), .NIB_W(4), .FORCE_NIB(FORCE_NIB)) u_dec (
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .busy       (busy),
    .we_track   (we_track),
    .we_sector  (we_sector),
    .we_data    (we_data),
    .cmd_accept (cmd_accept),
    .data_touch (data_touch)
  );

  fdc_track_ctr #(.DW(DW)) u_trk (
    .clk      (clk),
    .rst      (rst),
    .load_en  (we_track),
    .load_val (bus_wdata),
    .step_in  (step_in),
    .step_out (step_out),
    .track_q  (track_q)
  );

  fdc_data_hold #(.DW(DW)) u_dat (
    .clk       (clk),
    .rst       (rst),
    .bus_load  (we_data),
    .bus_val   (bus_wdata),
    .asm_valid (asm_valid),
    .asm_byte  (asm_byte),
    .ser_take  (ser_take),
    .bus_touch (data_touch),
    .data_q    (data_q),
    .drq       (drq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sector_q <= '0;
    end else if (we_sector) begin
      sector_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_out   <= '0;
      cmd_valid <= 1'b0;
    end else begin
      cmd_valid <= cmd_accept;
      if (cmd_accept) cmd_out <= bus_wdata;
    end
  end

  always_comb begin
    case (fdc_addr_e'(bus_addr))
      RA_STAT_CMD: rd_mux = status_in;
      RA_TRACK:    rd_mux = track_q;
      RA_SECTOR:   rd_mux = sector_q;
      default:     rd_mux = data_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end

  assign track_match  = (track_q == id_track);
  assign sector_match = (sector_q == id_sector);
  assign ser_byte     = data_q;
endmodule

// File: rtl/fdc_host_regs_chk.sv
module fdc_host_regs_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [1:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          busy,
  input logic [DW-1:0] status_in,
  input logic          cmd_valid,
  input logic          step_in,
  input logic          step_out,
  input logic          we_track,
  input logic [DW-1:0] track_q,
  input logic [DW-1:0] sector_q,
  input logic          asm_valid,
  input logic [DW-1:0] asm_byte,
  input logic [DW-1:0] ser_byte,
  input logic          drq
);
  // R1: reset clears the request flag and the command pulse
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!drq && !cmd_valid));

  // R2: address 0 reads return the status port
  a_r2_status_read: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_rd && bus_addr == 2'd0) |=> (bus_rdata == $past(status_in)));

  // R3: a lone step-in advances the track by one
  a_r3_step_in: assert property (@(posedge clk) disable iff (rst)
    (step_in && !step_out && !we_track) |=> (track_q == $past(track_q) + 1'b1));

  // R3: a lone step-out moves the track back by one
  a_r3_step_out: assert property (@(posedge clk) disable iff (rst)
    (step_out && !step_in && !we_track) |=> (track_q == $past(track_q) - 1'b1));

  // R4: a sector write while busy leaves the sector unchanged
  a_r4_sector_locked: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_sel && bus_wr && bus_addr == 2'd2) |=> $stable(sector_q));

  // R5: a non-interrupt command while busy gives no pulse
  a_r5_cmd_blocked: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_sel && bus_wr && bus_addr == 2'd0 && bus_wdata[DW-1:DW-4] != 4'hD)
      |=> !cmd_valid);

  // R7: an assembled byte lands in the data register
  a_r7_asm_load: assert property (@(posedge clk) disable iff (rst)
    asm_valid |=> (ser_byte == $past(asm_byte)));

  // R8: an assembled byte always raises the request flag
  a_r8_drq_set: assert property (@(posedge clk) disable iff (rst)
    asm_valid |=> drq);
endmodule

bind fdc_host_regs fdc_host_regs_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .busy      (busy),
  .status_in (status_in),
  .cmd_valid (cmd_valid),
  .step_in   (step_in),
  .step_out  (step_out),
  .we_track  (we_track),
  .track_q   (track_q),
  .sector_q  (sector_q),
  .asm_valid (asm_valid),
  .asm_byte  (asm_byte),
  .ser_byte  (ser_byte),
  .drq       (drq)
);

// File: tb/test_fdc_host_regs.sv
module test_fdc_host_regs;
  logic       clk = 1'b0;
  logic       rst;
  logic       bus_sel, bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       busy;
  logic [7:0] status_in, cmd_out;
  logic       cmd_valid, step_in, step_out;
  logic [7:0] id_track, id_sector;
  logic       track_match, sector_match;
  logic       asm_valid, ser_take, drq;
  logic [7:0] asm_byte, ser_byte;

  int  checks   = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  fdc_host_regs i_fdc_host_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .status_in(status_in), .cmd_out(cmd_out), .cmd_valid(cmd_valid),
    .step_in(step_in), .step_out(step_out), .id_track(id_track), .id_sector(id_sector),
    .track_match(track_match), .sector_match(sector_match), .asm_valid(asm_valid),
    .asm_byte(asm_byte), .ser_take(ser_take), .ser_byte(ser_byte), .drq(drq)
  );

  // vector: addr, write data, busy during write, expected read-back
  typedef struct packed {
    logic [1:0] addr;
    logic [7:0] wdata;
    logic       wbusy;
    logic [7:0] expect_rd;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'h12, 1'b0, 8'h12},
    '{2'd2, 8'h34, 1'b0, 8'h34},
    '{2'd3, 8'h56, 1'b0, 8'h56},
    '{2'd0, 8'h80, 1'b0, 8'hA5},
    '{2'd1, 8'h99, 1'b1, 8'h12},
    '{2'd2, 8'h77, 1'b1, 8'h34},
    '{2'd3, 8'hC3, 1'b1, 8'hC3},
    '{2'd1, 8'hFF, 1'b0, 8'hFF}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    rst = 1'b1; bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    busy = 0; status_in = 8'hA5; step_in = 0; step_out = 0;
    id_track = 8'h00; id_sector = 8'h01; asm_valid = 0; asm_byte = 0; ser_take = 0;
    idle(3);
    // R1 reset state
    check("R1 ser_byte", ser_byte, 8'h00);
    check("R1 cmd_out", cmd_out, 8'h00);
    check("R1 drq", {7'd0, drq}, 8'h00);
    check("R1 cmd_valid", {7'd0, cmd_valid}, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    check("R1 track zero via match", {7'd0, track_match}, 8'h01);
    rst = 1'b0;
    idle(1);

    // vector walk: R2 map, R4 busy lock, R7 data write not blocked
    for (int i = 0; i < NV; i++) begin
      busy = VECS[i].wbusy;
      bus_write(VECS[i].addr, VECS[i].wdata);
      busy = 1'b0;
      bus_read(VECS[i].addr, rv);
      check($sformatf("R2/R4 vector %0d", i), rv, VECS[i].expect_rd);
    end

    // R3: track is FF; wrap up, wrap down, both pulses
    step_in = 1; idle(1); step_in = 0;
    bus_read(2'd1, rv); check("R3 wrap up", rv, 8'h00);
    step_out = 1; idle(1); step_out = 0;
    bus_read(2'd1, rv); check("R3 wrap down", rv, 8'hFF);
    step_in = 1; step_out = 1; idle(1); step_in = 0; step_out = 0;
    bus_read(2'd1, rv); check("R3 both steps", rv, 8'hFF);
    step_in = 1; idle(3); step_in = 0;
    bus_read(2'd1, rv); check("R3 three steps in", rv, 8'h02);

    // R6 comparators
    id_track = 8'h02; id_sector = 8'h34; #1;
    check("R6 track match", {7'd0, track_match}, 8'h01);
    check("R6 sector match", {7'd0, sector_match}, 8'h01);
    id_track = 8'h03; id_sector = 8'h35; #1;
    check("R6 track mismatch", {7'd0, track_match}, 8'h00);
    check("R6 sector mismatch", {7'd0, sector_match}, 8'h00);

    // R9: track write together with step
    step_in = 1; bus_write(2'd1, 8'h40); step_in = 0;
    bus_read(2'd1, rv); check("R9 write beats step", rv, 8'h40);

    // R5 command acceptance
    idle(1);
    bus_write(2'd0, 8'h1A);
    check("R5 valid idle", {7'd0, cmd_valid}, 8'h01);
    check("R5 cmd idle", cmd_out, 8'h1A);
    idle(1);
    check("R5 pulse ends", {7'd0, cmd_valid}, 8'h00);
    busy = 1;
    bus_write(2'd0, 8'h20);
    check("R5 busy reject valid", {7'd0, cmd_valid}, 8'h00);
    check("R5 busy reject cmd", cmd_out, 8'h1A);
    bus_write(2'd0, 8'hD3);
    check("R5 force accepted", cmd_out, 8'hD3);
    check("R5 force valid", {7'd0, cmd_valid}, 8'h01);
    busy = 0;
    bus_read(2'd0, rv); check("R2 cmd not readable", rv, 8'hA5);

    // R7 / R8 data register and request flag
    asm_valid = 1; asm_byte = 8'h5A; idle(1); asm_valid = 0;
    check("R8 drq on byte", {7'd0, drq}, 8'h01);
    check("R7 ser_byte", ser_byte, 8'h5A);
    bus_read(2'd3, rv);
    check("R7 read byte", rv, 8'h5A);
    check("R8 drq cleared by read", {7'd0, drq}, 8'h00);
    asm_valid = 1; asm_byte = 8'h11; bus_write(2'd3, 8'h22); asm_valid = 0;
    check("R8 set beats write clear", {7'd0, drq}, 8'h01);
    bus_read(2'd3, rv); check("R7 asm beats bus write", rv, 8'h11);
    ser_take = 1; idle(1); ser_take = 0;
    check("R8 drq on ser_take", {7'd0, drq}, 8'h01);
    bus_write(2'd3, 8'h66);
    check("R8 drq cleared by write", {7'd0, drq}, 8'h00);
    check("R7 bus write to ser_byte", ser_byte, 8'h66);
    asm_valid = 1; asm_byte = 8'h77; bus_read(2'd3, rv); asm_valid = 0;
    check("R8 set beats read clear", {7'd0, drq}, 8'h01);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule